// File: doc/BRIEF.md
# ESOP Self-Test Response Checker

This block is the response end of a built-in self-test for an easily testable AND-EXOR (ESOP) network. While a deterministic generator applies its short test sequence, the checker captures three response bits on every valid beat: the network's function output and its two parity-check outputs. It compacts them into a 16-bit multiple-input signature register.

When the generator marks the last beat, the checker folds that beat in and compares the result with a correct signature fixed at elaboration time. It then raises either accept or reject and pulses done. A test run of an n-input network lasts n+6 beats. A start pulse clears the signature and the verdict, so the same checker can be used for any number of runs.

Top module: `esop_resp_checker`

## Requirements
- R1: While reset is asserted and after it is released, accept, reject and done are all low until a test run completes.
- R2: A start pulse clears the signature to zero and drops accept, reject and done on the next edge. A beat or end marker in the same cycle as start is discarded.
- R3: Each beat that is folded changes the signature in three steps. It shifts left by one. If the bit shifted out of position 15 was 1, it XORs with 0x1021 (x^16+x^12+x^5+1). It then XORs resp bit 0 (function output f), resp bit 1 (check output o1) and resp bit 2 (check output o2) into signature bits 0, 1 and 2.
- R4: Cycles with valid low leave the signature unchanged, whatever the response bits carry.
- R5: A valid beat with last high is folded and then compared with the parameter GOLDEN. On the following edge, accept rises if they are equal and reject rises otherwise.
- R6: done is high for exactly one cycle, the same cycle in which the verdict first appears.
- R7: accept and reject are never high together. Once set, the verdict holds until the next start, and beats or end markers that arrive after it are ignored.
- R8: Beats that arrive after reset but before the first start are ignored.
- R9: Flipping any single response bit on any beat of a fault-free run produces reject.
- R10: The end marker is ignored when valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a new run: clear signature and verdict |
| valid_i | input | 1 | Response bits are valid this cycle |
| last_i | input | 1 | This valid beat is the final one of the run |
| resp_i | input | 3 | bit 0 f, bit 1 o1, bit 2 o2 |
| accept_o | output | 1 | Signature matched GOLDEN |
| reject_o | output | 1 | Signature differed from GOLDEN |
| done_o | output | 1 | One-cycle strobe when the verdict is set |

## Verification
The final fold and the comparison happen in one cycle, so the last beat's bits must reach the verdict without an extra register. Every single-bit flip placed on the final beat has to turn into reject at that same edge. The other collision is start arriving together with a valid final beat. The bench drives both in one cycle and expects no done strobe and a cleared verdict. A following clean run must then accept. A cycle-by-cycle behavioural model judges every cycle in both scenarios.

// File: rtl/chk_pkg.sv
package chk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } chk_state_e;
endpackage

// File: rtl/chk_rst_sync.sv
module chk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/chk_misr.sv
module chk_misr #(
  parameter int              W    = 16,
  parameter int              N    = 3,
  parameter logic [W-1:0]    POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [N-1:0] data_i,
  output logic [W-1:0] fold_o
);
  logic [W-1:0] sig_q;
  logic [W-1:0] sig_d;
  logic [W-1:0] shifted;
  logic [W-1:0] injected;

  always_comb shifted = {sig_q[W-2:0], 1'b0} ^ (sig_q[W-1] ? POLY : '0);

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_inj
      if (g < N) begin : g_tap
        assign injected[g] = shifted[g] ^ data_i[g];
      end else begin : g_pass
        assign injected[g] = shifted[g];
      end
    end
  endgenerate

  always_comb begin
    if (clr_i)     sig_d = '0;
    else if (en_i) sig_d = injected;
    else           sig_d = sig_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig_d;
  end

  assign fold_o = injected;

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !en_i) |=> $stable(sig_q));
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sig_q == '0));
endmodule

// File: rtl/chk_seq.sv
module chk_seq
  import chk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic valid_i,
  input  logic last_i,
  output logic clr_o,
  output logic fold_o,
  output logic final_o
);
  chk_state_e state_q;
  chk_state_e state_d;

  always_comb begin
    clr_o   = start_i;
    fold_o  = !start_i && (state_q == ST_RUN) && valid_i;
    final_o = fold_o && last_i;
    state_d = state_q;
    if (start_i)      state_d = ST_RUN;
    else if (final_o) state_d = ST_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !fold_o);
  assert_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && !start_i) |=> (state_q == ST_DONE));
endmodule

// File: rtl/chk_verdict.sv
module chk_verdict #(
  parameter int           W      = 16,
  parameter logic [W-1:0] GOLDEN = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         final_i,
  input  logic [W-1:0] sig_i,
  output logic         accept_o,
  output logic         reject_o,
  output logic         done_o
);
  logic acc_q, acc_d, rej_q, rej_d, done_q, done_d;
  logic match;

  always_comb begin
    match  = (sig_i == GOLDEN);
    done_d = final_i && !clr_i;
    acc_d  = acc_q;
    rej_d  = rej_q;
    if (clr_i) begin
      acc_d = 1'b0;
      rej_d = 1'b0;
    end else if (final_i) begin
      acc_d = match;
      rej_d = !match;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      rej_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      rej_q  <= rej_d;
      done_q <= done_d;
    end
  end

  assign accept_o = acc_q;
  assign reject_o = rej_q;
  assign done_o   = done_q;

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_o && reject_o));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((accept_o || reject_o) && !clr_i) |=> $stable({accept_o, reject_o}));
  assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (accept_o ^ reject_o));
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!accept_o && !reject_o && !done_o));
endmodule

// File: rtl/esop_resp_checker.sv
module esop_resp_checker #(
  parameter int           SIG_W     = 16,
  parameter int           NUM_RESP  = 3,
  parameter logic [SIG_W-1:0] POLY  = 16'h1021,
  parameter logic [SIG_W-1:0] GOLDEN = 16'h0000,
  parameter int           SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                valid_i,
  input  logic                last_i,
  input  logic [NUM_RESP-1:0] resp_i,
  output logic                accept_o,
  output logic                reject_o,
  output logic                done_o
);
  logic             rst_int_n;
  logic             clr;
  logic             fold_en;
  logic             final_beat;
  logic [SIG_W-1:0] fold_val;

  chk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  chk_seq u_seq (
    .clk(clk), .rst_n(rst_int_n), .start_i(start_i), .valid_i(valid_i),
    .last_i(last_i), .clr_o(clr), .fold_o(fold_en), .final_o(final_beat)
  );

  chk_misr #(.W(SIG_W), .N(NUM_RESP), .POLY(POLY)) u_misr (
    .clk(clk), .rst_n(rst_int_n), .clr_i(clr), .en_i(fold_en),
    .data_i(resp_i), .fold_o(fold_val)
  );

  chk_verdict #(.W(SIG_W), .GOLDEN(GOLDEN)) u_verdict (
    .clk(clk), .rst_n(rst_int_n), .clr_i(clr), .final_i(final_beat),
    .sig_i(fold_val), .accept_o(accept_o), .reject_o(reject_o),
    .done_o(done_o)
  );

  assert_nolast_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!valid_i) |=> !done_o);
endmodule

// File: tb/sim_esop_resp_checker.sv
module sim_esop_resp_checker;
  localparam int NVEC = 14;  // n = 8 inputs -> n+6 beats

  function automatic logic [2:0] good_resp(input int k);
    int t;
    t = k * 7 + (k >> 2) * 3 + 1;
    return t[2:0];
  endfunction

  function automatic logic [15:0] fold(input logic [15:0] m, input logic [2:0] b);
    int v;
    v = int'(m) << 1;
    if ((v & 32'h10000) != 0) v = v ^ 32'h11021;
    v = v ^ int'(b);
    return v[15:0];
  endfunction

  function automatic logic [15:0] calc_gold();
    logic [15:0] m;
    m = '0;
    for (int k = 0; k < NVEC; k++) m = fold(m, good_resp(k));
    return m;
  endfunction

  localparam logic [15:0] GOLD = calc_gold();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, valid_i = 1'b0, last_i = 1'b0;
  logic [2:0] resp_i = '0;
  logic accept_o, reject_o, done_o;

  always #5 clk = ~clk;

  esop_resp_checker #(.GOLDEN(GOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
    .last_i(last_i), .resp_i(resp_i), .accept_o(accept_o),
    .reject_o(reject_o), .done_o(done_o)
  );

  int vectors = 0, fails = 0;
  bit finished = 0;
  logic [15:0] m_sig = '0;
  int m_st = 0;
  logic m_acc = 0, m_rej = 0, m_done = 0;

  task automatic check(input bit ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual acc/rej/done=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rst_n) begin
      m_sig = '0; m_st = 0; m_acc = 0; m_rej = 0; m_done = 0;
    end else if (start_i) begin
      m_sig = '0; m_st = 1; m_acc = 0; m_rej = 0; m_done = 0;
    end else if (m_st == 1 && valid_i) begin
      m_sig = fold(m_sig, resp_i);
      m_done = last_i;
      if (last_i) begin
        m_acc = (m_sig == GOLD); m_rej = (m_sig != GOLD); m_st = 2;
      end
    end else m_done = 0;
    #1;
    check({accept_o, reject_o, done_o} === {m_acc, m_rej, m_done},
          "R3 R5 R6 model compare", {accept_o, reject_o, done_o}, {m_acc, m_rej, m_done});
  endtask

  task automatic cyc(input logic s, input logic v, input logic l, input logic [2:0] b);
    @(negedge clk);
    start_i = s; valid_i = v; last_i = l; resp_i = b;
    tick();
  endtask

  task automatic idle();
    cyc(0, 0, 0, 3'b000);
  endtask

  // full run; flip_k < 0 means fault-free
  task automatic run_seq(input int flip_k, input int flip_b, input bit gaps);
    logic [2:0] b;
    cyc(1, 0, 0, 3'b000);
    for (int k = 0; k < NVEC; k++) begin
      b = good_resp(k);
      if (k == flip_k) b[flip_b] = ~b[flip_b];
      if (gaps && k % 3 == 1) cyc(0, 0, 1, 3'b111);  // R4, R10 gap with junk
      cyc(0, 1, (k == NVEC - 1), b);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check({accept_o, reject_o, done_o} === 3'b000, "R1 in reset", {accept_o, reject_o, done_o}, 3'b000);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) idle();
    check({accept_o, reject_o, done_o} === 3'b000, "R1 after release", {accept_o, reject_o, done_o}, 3'b000);

    // R8: beats before the first start
    for (int k = 0; k < 5; k++) cyc(0, 1, 1, 3'b101);
    idle();
    check({accept_o, reject_o, done_o} === 3'b000, "R8 beats ignored", {accept_o, reject_o, done_o}, 3'b000);

    // R3 R5 R6: clean run
    run_seq(-1, 0, 0);
    check(accept_o && !reject_o && done_o, "R5 R6 clean accept", {accept_o, reject_o, done_o}, 3'b101);
    idle();
    check(accept_o && !done_o, "R6 done single cycle", {accept_o, reject_o, done_o}, 3'b100);

    // R7: beats and last after the verdict
    for (int k = 0; k < 4; k++) cyc(0, 1, 1, 3'b111);
    check(accept_o && !reject_o && !done_o, "R7 held after verdict", {accept_o, reject_o, done_o}, 3'b100);

    // R4 R10: run with gaps carrying junk and a stray end marker
    run_seq(-1, 0, 1);
    check(accept_o && !reject_o && done_o, "R4 R10 gapped run accept", {accept_o, reject_o, done_o}, 3'b101);

    // R2: start collides with a valid final beat
    cyc(1, 0, 0, 3'b000);
    for (int k = 0; k < 5; k++) cyc(0, 1, 0, good_resp(k));
    cyc(1, 1, 1, 3'b011);
    check({accept_o, reject_o, done_o} === 3'b000, "R2 start wins over last", {accept_o, reject_o, done_o}, 3'b000);
    for (int k = 0; k < NVEC; k++) cyc(0, 1, (k == NVEC - 1), good_resp(k));
    check(accept_o && !reject_o && done_o, "R2 clean after collision", {accept_o, reject_o, done_o}, 3'b101);

    // R2: restart mid-run
    cyc(1, 0, 0, 3'b000);
    for (int k = 0; k < 6; k++) cyc(0, 1, 0, 3'b110);
    run_seq(-1, 0, 0);
    check(accept_o && done_o, "R2 restart mid-run", {accept_o, reject_o, done_o}, 3'b101);

    // R9: every single-bit flip on every beat
    for (int k = 0; k < NVEC; k++) begin
      for (int b = 0; b < 3; b++) begin
        run_seq(k, b, 0);
        check(!accept_o && reject_o && done_o, "R9 single flip reject", {accept_o, reject_o, done_o}, 3'b011);
      end
    end
    idle();
    cyc(0, 1, 1, good_resp(0));
    check(reject_o && !accept_o && !done_o, "R7 reject held", {accept_o, reject_o, done_o}, 3'b010);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule